// File: doc/BRIEF.md
# CAM Host Strobe Decoder and Match Chain Controller

This block sits between a host bus and an asynchronous content-addressable memory. It turns the host's active-low strobes into clocked cycle control and drives one link of a priority match chain. A fast system clock samples the chip enable, the write enable, the command/data select and the chain enable through a two-stage synchronizer. A falling chip enable opens a cycle: the block captures the other three controls and decodes one of four cycle kinds. A rising chip enable closes the cycle: writes commit, the bus driver releases, a one-clock segment-advance pulse is issued, and the match output is updated.

The data bus is split into an input, an output and an output enable, so that a pad ring can form the tri-state pin. A read drives either the data register or a status word. The cycle kind is fixed by the latched command select. The match output is active low. With the chain enabled for the cycle, it reports a local hit or an upstream hit. A command register bit can mask the local hit, so that only the upstream flag passes through. Changing the active configuration bank forces the flag inactive.

Top module: `cam_host_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it, `match_out_n` is 1, `bus_oe` is 0, `seg_adv` is 0 and `cmd_word` and `data_word` are 0.
- R2: The cycle kind is {`host_wr_n`,`host_cmd_n`} sampled at the enable's falling edge: 00 command write, 01 data write, 10 command read, 11 data read. For either read, `bus_oe` is 1 from the third clock edge after `host_en_n` falls. A data read drives `data_word`. A command read drives a status word with bit 0 = match-flag enable, bit 1 = configuration bank, bit 2 = `match_out_n`, and all other bits 0.
- R3: Changes on `host_wr_n` or `host_cmd_n` after the falling edge do not alter the open cycle.
- R4: A command write loads `bus_in` into `cmd_word`, and a data write loads it into `data_word`. Each load happens on the third clock edge after `host_en_n` rises. Reads change neither register.
- R5: `bus_oe` falls on the third clock edge after `host_en_n` rises. `bus_out` is 0 whenever `bus_oe` is 0.
- R6: Each enable cycle gives exactly one one-clock `seg_adv` pulse, on the third edge after `host_en_n` rises.
- R7: If `chain_en_n` was 0 at the falling edge and `cmd_word` bit 0 is 1, then `match_out_n` becomes NOT(`local_match` OR NOT `match_in_n`). This happens on the same edge as `seg_adv`.
- R8: If the chain is enabled and `cmd_word` bit 0 is 0, then `match_out_n` takes the value of `match_in_n` on that edge.
- R9: If `chain_en_n` was 1 at the falling edge, then `match_out_n` becomes 1.
- R10: A command write whose bit 1 differs from the current `cmd_word` bit 1 sets `match_out_n` to 1, whatever the match inputs are.
- R11: `match_out_n` changes only on edges where `seg_adv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en_n | input | 1 | Asynchronous chip enable, active low |
| host_wr_n | input | 1 | Write enable, low = write |
| host_cmd_n | input | 1 | Low = command, high = data |
| chain_en_n | input | 1 | Match chain enable, active low |
| bus_in | input | 16 | Bus value from the pads |
| bus_out | output | 16 | Value driven to the pads |
| bus_oe | output | 1 | Pad output enable |
| local_match | input | 1 | Local compare result, high = hit |
| match_in_n | input | 1 | Upstream match flag, active low |
| match_out_n | output | 1 | Chained match flag, active low |
| seg_adv | output | 1 | Segment counter advance pulse |
| cmd_word | output | 16 | Command register |
| data_word | output | 16 | Data register |

## Verification
Each strobe edge takes two synchronizer flops plus one edge-detect register. The bus enable therefore rises on the third edge after the enable falls. Register loads, the advance pulse and the new match flag all land on the third edge after it rises. The bench drives each strobe on a falling clock edge and counts exactly three rising edges before it samples just after the edge. It also samples one edge earlier, to show that nothing has moved yet, and one edge later, to show the pulse has ended and the flag is held.

// File: rtl/cam_host_pkg.sv
package cam_host_pkg;

    // Cycle kind encoded as {write_n, command_n}
    typedef enum logic [1:0] {
        CYC_CMD_WR = 2'b00,
        CYC_DAT_WR = 2'b01,
        CYC_CMD_RD = 2'b10,
        CYC_DAT_RD = 2'b11
    } cyc_e;

    typedef struct packed {
        logic busy;
        cyc_e cyc;
        logic chain_on;
    } hold_t;

    localparam int MFEN_BIT  = 0;
    localparam int CFG_BIT   = 1;
    localparam int MFLAG_BIT = 2;

    function automatic cyc_e decode_cycle(input logic wr_n, input logic cmd_n);
        return cyc_e'({wr_n, cmd_n});
    endfunction

    function automatic logic cyc_is_read(input cyc_e c);
        return c[1];
    endfunction

    function automatic logic cyc_is_cmd(input cyc_e c);
        return !c[0];
    endfunction

endpackage

// File: rtl/cam_strobe_sync.sv
module cam_strobe_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cam_edge_det.sv
module cam_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall_p,
    output logic rise_p
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl;
    end

    assign fall_p = prev_q & ~lvl;
    assign rise_p = ~prev_q & lvl;
endmodule

// File: rtl/cam_cycle_ctrl.sv
module cam_cycle_ctrl
    import cam_host_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_p,
    input  logic              rise_p,
    input  logic              wr_s,
    input  logic              cmd_s,
    input  logic              chain_s,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              match_out_n,
    output logic              commit,
    output logic              chain_on,
    output logic              cfg_flip,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] cmd_word,
    output logic [DATA_W-1:0] data_word,
    output logic              seg_adv
);
    hold_t             hold_q;
    logic [DATA_W-1:0] cmd_q, data_q, status;
    logic              seg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '{busy: 1'b0, cyc: CYC_DAT_RD, chain_on: 1'b0};
            cmd_q  <= '0;
            data_q <= '0;
            seg_q  <= 1'b0;
        end else begin
            seg_q <= 1'b0;
            if (fall_p && !hold_q.busy) begin
                hold_q.busy     <= 1'b1;
                hold_q.cyc      <= decode_cycle(wr_s, cmd_s);
                hold_q.chain_on <= !chain_s;
            end else if (rise_p && hold_q.busy) begin
                hold_q.busy <= 1'b0;
                seg_q       <= 1'b1;
                if (hold_q.cyc == CYC_CMD_WR)      cmd_q  <= bus_in;
                else if (hold_q.cyc == CYC_DAT_WR) data_q <= bus_in;
            end
        end
    end

    always_comb begin
        status            = '0;
        status[MFEN_BIT]  = cmd_q[MFEN_BIT];
        status[CFG_BIT]   = cmd_q[CFG_BIT];
        status[MFLAG_BIT] = match_out_n;
    end

    assign commit   = rise_p & hold_q.busy;
    assign chain_on = hold_q.chain_on;
    assign cfg_flip = (hold_q.cyc == CYC_CMD_WR) && (bus_in[CFG_BIT] != cmd_q[CFG_BIT]);
    assign bus_oe   = hold_q.busy & cyc_is_read(hold_q.cyc);
    assign bus_out  = !bus_oe ? '0 : (cyc_is_cmd(hold_q.cyc) ? status : data_q);
    assign cmd_word  = cmd_q;
    assign data_word = data_q;
    assign seg_adv   = seg_q;
endmodule

// File: rtl/cam_match_chain.sv
module cam_match_chain (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic chain_on,
    input  logic mf_en,
    input  logic cfg_flip,
    input  logic local_match,
    input  logic match_in_n,
    output logic match_out_n
);
    logic flag_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_n_q <= 1'b1;
        end else if (commit) begin
            if (cfg_flip || !chain_on) flag_n_q <= 1'b1;
            else if (mf_en)            flag_n_q <= ~(local_match | ~match_in_n);
            else                       flag_n_q <= match_in_n;
        end
    end

    assign match_out_n = flag_n_q;
endmodule

// File: rtl/cam_host_ctrl.sv
module cam_host_ctrl
    import cam_host_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en_n,
    input  logic              host_wr_n,
    input  logic              host_cmd_n,
    input  logic              chain_en_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              local_match,
    input  logic              match_in_n,
    output logic              match_out_n,
    output logic              seg_adv,
    output logic [DATA_W-1:0] cmd_word,
    output logic [DATA_W-1:0] data_word
);
    localparam int NSTROBE = 4;

    logic [NSTROBE-1:0] strobe_s;
    logic fall_p, rise_p, commit, chain_on, cfg_flip;

    cam_strobe_sync #(.W(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
        .clk (clk),
        .rst (rst),
        .din ({host_en_n, host_wr_n, host_cmd_n, chain_en_n}),
        .dout(strobe_s)
    );

    cam_edge_det i_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (strobe_s[3]),
        .fall_p(fall_p),
        .rise_p(rise_p)
    );

    cam_cycle_ctrl #(.DATA_W(DATA_W)) i_cyc (
        .clk        (clk),
        .rst        (rst),
        .fall_p     (fall_p),
        .rise_p     (rise_p),
        .wr_s       (strobe_s[2]),
        .cmd_s      (strobe_s[1]),
        .chain_s    (strobe_s[0]),
        .bus_in     (bus_in),
        .match_out_n(match_out_n),
        .commit     (commit),
        .chain_on   (chain_on),
        .cfg_flip   (cfg_flip),
        .bus_oe     (bus_oe),
        .bus_out    (bus_out),
        .cmd_word   (cmd_word),
        .data_word  (data_word),
        .seg_adv    (seg_adv)
    );

    cam_match_chain i_chain (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .chain_on   (chain_on),
        .mf_en      (cmd_word[MFEN_BIT]),
        .cfg_flip   (cfg_flip),
        .local_match(local_match),
        .match_in_n (match_in_n),
        .match_out_n(match_out_n)
    );
endmodule

// File: rtl/cam_host_ctrl_chk.sv
module cam_host_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              seg_adv,
    input logic              match_out_n,
    input logic [DATA_W-1:0] cmd_word,
    input logic [DATA_W-1:0] data_word
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (match_out_n && !bus_oe && !seg_adv));

    assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0));

    assert_adv_single_R6: assert property (@(posedge clk) disable iff (rst)
        seg_adv |=> !seg_adv);

    assert_adv_bus_off_R5: assert property (@(posedge clk) disable iff (rst)
        seg_adv |-> !bus_oe);

    assert_flag_locked_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(match_out_n) |-> seg_adv);

    assert_cmd_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_word) |-> seg_adv);

    assert_data_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_word) |-> seg_adv);
endmodule

bind cam_host_ctrl cam_host_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out),
    .seg_adv    (seg_adv),
    .match_out_n(match_out_n),
    .cmd_word   (cmd_word),
    .data_word  (data_word)
);

// File: tb/test_cam_host_ctrl.sv
module test_cam_host_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_en_n = 1'b1, host_wr_n = 1'b1, host_cmd_n = 1'b1, chain_en_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic        local_match = 1'b0, match_in_n = 1'b1;
    logic        match_out_n, seg_adv;
    logic [15:0] cmd_word, data_word;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_cmd  = '0;
    logic [15:0] exp_data = '0;
    logic        exp_mf   = 1'b1;

    always #2 clk = ~clk;

    cam_host_ctrl i_cam_host_ctrl (
        .clk(clk), .rst(rst),
        .host_en_n(host_en_n), .host_wr_n(host_wr_n), .host_cmd_n(host_cmd_n),
        .chain_en_n(chain_en_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .local_match(local_match), .match_in_n(match_in_n), .match_out_n(match_out_n),
        .seg_adv(seg_adv), .cmd_word(cmd_word), .data_word(data_word)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One complete enable cycle; kind = {wr_n, cmd_n}
    task automatic run_cycle(input logic wr, input logic cmd, input logic chn,
                             input logic [15:0] din, input logic lm, input logic mi,
                             input logic flip_mid);
        logic [15:0] rd_exp;
        logic        flip;
        string       mreq;
        @(negedge clk);
        host_wr_n = wr; host_cmd_n = cmd; chain_en_n = chn;
        bus_in = din; local_match = lm; match_in_n = mi; host_en_n = 1'b0;
        repeat (3) @(posedge clk); #1;
        check({15'd0, bus_oe}, {15'd0, wr}, "R2 oe");
        rd_exp = cmd ? exp_data : {13'd0, exp_mf, exp_cmd[1], exp_cmd[0]};
        if (wr) check(bus_out, rd_exp, "R2 read value");
        else    check(bus_out, 16'h0, "R5 bus idle on write");
        if (flip_mid) begin
            @(negedge clk);
            host_wr_n = ~wr; host_cmd_n = ~cmd;
            repeat (3) @(posedge clk); #1;
            check({15'd0, bus_oe}, {15'd0, wr}, "R3 oe kept");
            if (wr) check(bus_out, rd_exp, "R3 read kept");
        end
        @(negedge clk);
        host_en_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        check({15'd0, seg_adv}, 16'd0, "R6 no early pulse");
        check({15'd0, bus_oe}, {15'd0, wr}, "R5 oe held until release");
        // expected outcome
        flip = (!wr && !cmd) && (din[1] != exp_cmd[1]);
        if (flip)          begin exp_mf = 1'b1;            mreq = "R10"; end
        else if (chn)      begin exp_mf = 1'b1;            mreq = "R9";  end
        else if (exp_cmd[0]) begin exp_mf = ~(lm | ~mi);   mreq = "R7";  end
        else               begin exp_mf = mi;              mreq = "R8";  end
        if (!wr && !cmd) exp_cmd  = din;
        if (!wr &&  cmd) exp_data = din;
        @(posedge clk); #1;
        check({15'd0, seg_adv}, 16'd1, "R6 pulse");
        check({15'd0, bus_oe}, 16'd0, "R5 oe released");
        check({15'd0, match_out_n}, {15'd0, exp_mf}, mreq);
        check(cmd_word, exp_cmd, "R4 cmd");
        check(data_word, exp_data, "R4 data");
        @(posedge clk); #1;
        check({15'd0, seg_adv}, 16'd0, "R6 pulse ends");
        check({15'd0, match_out_n}, {15'd0, exp_mf}, "R11 held");
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk); #1;
        check({15'd0, match_out_n}, 16'd1, "R1 flag");
        check({15'd0, bus_oe}, 16'd0, "R1 oe");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check({15'd0, match_out_n}, 16'd1, "R1 flag after");
        check({15'd0, bus_oe}, 16'd0, "R1 oe after");
        check({15'd0, seg_adv}, 16'd0, "R1 pulse");
        check(cmd_word, 16'd0, "R1 cmd");
        check(data_word, 16'd0, "R1 data");

        // basic kinds
        run_cycle(1'b0, 1'b1, 1'b1, 16'hA5C3, 1'b0, 1'b1, 1'b0);
        run_cycle(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b0);
        run_cycle(1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0);

        // sweep: flag enable x chain x local x upstream x cycle kind
        for (int mfen = 0; mfen < 2; mfen++) begin
            run_cycle(1'b0, 1'b0, 1'b1, {14'h0, exp_cmd[1], 1'(mfen)}, 1'b0, 1'b1, 1'b0);
            for (int idx = 0; idx < 8; idx++) begin
                logic chn, lm, mi, wr, cmd;
                logic [15:0] din;
                chn = idx[2]; lm = idx[1]; mi = idx[0];
                {wr, cmd} = 2'(idx) ^ 2'b11;
                if (!wr && !cmd) din = {12'(idx + 16 * mfen), 2'b00, exp_cmd[1], exp_cmd[0]};
                else             din = 16'h3C00 ^ (16'(idx) * 16'h0111) ^ 16'(mfen);
                run_cycle(wr, cmd, chn, din, lm, mi, 1'b0);
            end
        end

        // R10: bank change forces flag inactive
        run_cycle(1'b0, 1'b0, 1'b0, 16'h0001, 1'b1, 1'b1, 1'b0);
        run_cycle(1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
        run_cycle(1'b0, 1'b0, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0);
        run_cycle(1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
        run_cycle(1'b0, 1'b0, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0);

        // R3: controls toggled mid-cycle
        run_cycle(1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1);
        run_cycle(1'b0, 1'b1, 1'b1, 16'h5A5A, 1'b1, 1'b0, 1'b1);
        run_cycle(1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule